// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Shift Engine

This block moves one short command of up to eight bits between a processor and a serial EEPROM on a three-wire bus: a serial clock, one bidirectional data line and a chip select. The chip select is driven elsewhere by firmware. Firmware first loads the 8-bit data register and then writes the control register. That control write starts a burst of serial clocks. In the burst the engine either shifts the data register out, most significant bit first, or samples the device into it. The serial clock is derived from the system clock. A busy flag covers the whole command, and a one-cycle interrupt pulse marks its end.

Two options shape the end of a command. The release option floats the data line straight after the last serial clock rising edge, which hands the line to the device. The wait-for-ready option uses that released line: busy stays high until the device pulls the data line high, so the interrupt arrives when an internal EEPROM write cycle has finished.

The engine is built around one state machine. Its states are IDLE (no command), SHIFT_LO (serial clock low, data set up), SHIFT_HI (serial clock high, data sampled), WAIT_RDY (clocks done, waiting for a rising edge on the data line) and END (one closing cycle). It has these transitions:
- IDLE→SHIFT_LO on a start with a nonzero count.
- IDLE→END on a start with a zero count.
- IDLE→WAIT_RDY on a start with a zero count and wait active.
- SHIFT_LO→SHIFT_HI on a divider tick.
- SHIFT_HI→SHIFT_LO on a tick while bits remain.
- SHIFT_HI→WAIT_RDY or SHIFT_HI→END on a tick after the last bit.
- WAIT_RDY→END on a rising edge of the data line.
- END→IDLE always.

Top module: `uw_shift_engine`

## Requirements
- R1: A control write is accepted only while busy (`ctrl_q[7]`) is 0. An accepted write sets busy from the next clock edge until the command ends. A control write while busy changes neither `ctrl_q[6:0]` nor the serial activity.
- R2: The serial clock idles low. Each high and low phase lasts SYS_CLK_HZ/(2·SCLK_HZ) system clocks, which is 250 at the default settings.
- R3: Control bit 4 = 0 selects a write. A write sends the count number of bits, taken MSB first from the data register starting at bit 7. `sd_out` changes only on a serial clock falling edge or at command start, and is stable at every rising edge.
- R4: Control bit 4 = 1 selects a read. A read samples `sd_in` at each serial clock rising edge, MSB first. When busy falls, the bits appear right-justified in `data_q`, with the bits above them cleared. `sd_oe` is 0 during the read clocks.
- R5: Control bits [3:0] hold the clock count. A count of 0 issues no serial clocks. Afterwards the line follows control bit 5: driven (`sd_oe`=1, `sd_out`=0) when that bit is 0, floated when it is 1.
- R6: A requested count above 8 is stored and performed as 8. `ctrl_q[3:0]` never exceeds 8.
- R7: Control bit 5 = 1 floats the line (`sd_oe`=0) in the same cycle as the last serial clock rising edge, while the clock is still high. With bit 5 = 0 the line is driven once the command has ended. Whenever busy is 0, `sd_oe` equals the inverse of `ctrl_q[5]`.
- R8: `irq` is high for exactly one cycle, the first cycle in which busy is 0 after being 1, and at no other time.
- R9: Control bit 6 = 1 together with bit 5 = 1 keeps busy high after the last clock until a rising edge is seen on `sd_in`. With bit 5 = 0, bit 6 has no effect.
- R10: After reset: `sck`=0, busy=0, `sd_oe`=1, `sd_out`=0, `irq`=0, `data_q`=0, `ctrl_q`=0.
- R11: A data register write while busy is 0 loads `data_q`. A data write while busy is 1 is ignored. Otherwise `data_q` changes only when a read ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| data_wr_en | input | 1 | Data register write strobe |
| data_wr_val | input | 8 | Value for the data register |
| ctrl_wr_en | input | 1 | Control register write strobe; starts a command |
| ctrl_wr_val | input | 8 | [3:0] count, [4] read, [5] release, [6] wait-for-ready |
| data_q | output | 8 | Data register readback |
| ctrl_q | output | 8 | Control readback, busy in bit 7 |
| sck | output | 1 | Serial clock |
| sd_out | output | 1 | Serial data output value |
| sd_oe | output | 1 | Serial data output enable |
| sd_in | input | 1 | Serial data line as seen at the pad |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The checker watches the following on every cycle:
- the serial clock stays low while idle and rises only inside a command;
- the count readback stays at or below eight;
- the configuration and data registers hold still while busy;
- the output enable outside a command matches the release bit;
- the interrupt matches each falling edge of busy one for one.

Only the directed scenarios can show the following:
- the bit order and exact values shifted out or captured, including right justification for short reads;
- the half-period length of the serial clock;
- the release happening while the final clock is still high;
- wait-for-ready holding busy until the device drives the line high, and having no effect without release.

// File: rtl/uw_pkg.sv
package uw_pkg;

    localparam int DATA_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LO,
        ST_HI,
        ST_WAIT,
        ST_END
    } uw_state_e;

    typedef struct packed {
        logic             wfr;
        logic             rel;
        logic             rd;
        logic [CNT_W-1:0] cnt;
    } uw_cmd_t;

    function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CNT_W-1:0] req);
        return (req > CNT_W'(DATA_W)) ? CNT_W'(DATA_W) : req;
    endfunction

endpackage

// File: rtl/uw_clkdiv.sv
module uw_clkdiv #(
    parameter int HALF = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF < 2) ? 1 : $clog2(HALF);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear || !run) begin
            count <= '0;
        end else if (count == LAST) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

    assign tick = run && (count == LAST);
endmodule

// File: rtl/uw_fsm.sv
module uw_fsm
    import uw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      start_cnt_zero,
    input  logic      start_wait,
    input  logic      cfg_wait,
    input  logic      tick,
    input  logic      bits_zero,
    input  logic      rdy_rise,
    output uw_state_e state
);
    uw_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (!start_cnt_zero) state_nx = ST_LO;
                    else if (start_wait) state_nx = ST_WAIT;
                    else                 state_nx = ST_END;
                end
            end
            ST_LO: begin
                if (tick) state_nx = ST_HI;
            end
            ST_HI: begin
                if (tick) begin
                    if (!bits_zero)    state_nx = ST_LO;
                    else if (cfg_wait) state_nx = ST_WAIT;
                    else               state_nx = ST_END;
                end
            end
            ST_WAIT: begin
                if (rdy_rise) state_nx = ST_END;
            end
            ST_END: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end
endmodule

// File: rtl/uw_shifter.sv
module uw_shifter
    import uw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_rd,
    input  logic [CNT_W-1:0]  start_cnt,
    input  logic [DATA_W-1:0] load_val,
    input  logic              rise,
    input  logic              fall,
    input  logic              rd,
    input  logic              sd_in,
    output logic [DATA_W-1:0] shreg,
    output logic [CNT_W-1:0]  bits_left,
    output logic              sd_out
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            bits_left <= '0;
            sd_out    <= 1'b0;
        end else if (start) begin
            bits_left <= start_cnt;
            shreg     <= start_rd ? '0 : load_val;
            sd_out    <= (start_rd || start_cnt == '0) ? 1'b0 : load_val[DATA_W-1];
        end else if (rise) begin
            bits_left <= bits_left - 1'b1;
            if (rd) shreg <= {shreg[DATA_W-2:0], sd_in};
        end else if (fall && bits_left != '0 && !rd) begin
            shreg  <= {shreg[DATA_W-2:0], 1'b0};
            sd_out <= shreg[DATA_W-2];
        end
    end
endmodule

// File: rtl/uw_shift_engine.sv
module uw_shift_engine
    import uw_pkg::*;
#(
    parameter int SYS_CLK_HZ = 250_000_000,
    parameter int SCLK_HZ    = 500_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       data_wr_en,
    input  logic [7:0] data_wr_val,
    input  logic       ctrl_wr_en,
    input  logic [7:0] ctrl_wr_val,
    output logic [7:0] data_q,
    output logic [7:0] ctrl_q,
    output logic       sck,
    output logic       sd_out,
    output logic       sd_oe,
    input  logic       sd_in,
    output logic       irq
);
    localparam int HALF_RAW = SYS_CLK_HZ / (2 * SCLK_HZ);
    localparam int HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;

    uw_state_e         state;
    uw_cmd_t           cfg;
    logic              tick;
    logic              start;
    logic              busy;
    logic              rdy_rise;
    logic              sd_in_d;
    logic              rise_ev;
    logic              fall_ev;
    logic [CNT_W-1:0]  cnt_req;
    logic [CNT_W-1:0]  bits_left;
    logic [DATA_W-1:0] shreg;

    assign cnt_req  = clamp_cnt(ctrl_wr_val[3:0]);
    assign busy     = (state != ST_IDLE);
    assign start    = ctrl_wr_en && !busy;
    assign rdy_rise = sd_in && !sd_in_d;
    assign rise_ev  = (state == ST_LO) && tick;
    assign fall_ev  = (state == ST_HI) && tick;
    assign ctrl_q   = {busy, cfg.wfr, cfg.rel, cfg.rd, cfg.cnt};

    uw_clkdiv #(.HALF(HALF)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .run   (state == ST_LO || state == ST_HI),
        .tick  (tick)
    );

    uw_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .start_cnt_zero (cnt_req == '0),
        .start_wait     (ctrl_wr_val[6] && ctrl_wr_val[5]),
        .cfg_wait       (cfg.wfr && cfg.rel),
        .tick           (tick),
        .bits_zero      (bits_left == '0),
        .rdy_rise       (rdy_rise),
        .state          (state)
    );

    uw_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_rd  (ctrl_wr_val[4]),
        .start_cnt (cnt_req),
        .load_val  (data_q),
        .rise      (rise_ev),
        .fall      (fall_ev),
        .rd        (cfg.rd),
        .sd_in     (sd_in),
        .shreg     (shreg),
        .bits_left (bits_left),
        .sd_out    (sd_out)
    );

    // Output and register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg     <= '0;
            data_q  <= '0;
            sck     <= 1'b0;
            sd_oe   <= 1'b1;
            irq     <= 1'b0;
            sd_in_d <= 1'b0;
        end else begin
            sd_in_d <= sd_in;
            irq     <= (state == ST_END);
            if (data_wr_en && !busy) data_q <= data_wr_val;
            if (start) begin
                cfg.cnt <= cnt_req;
                cfg.rd  <= ctrl_wr_val[4];
                cfg.rel <= ctrl_wr_val[5];
                cfg.wfr <= ctrl_wr_val[6];
                sd_oe   <= (cnt_req == '0) ? !ctrl_wr_val[5] : !ctrl_wr_val[4];
            end
            if (rise_ev) begin
                sck <= 1'b1;
                if (bits_left == CNT_W'(1)) sd_oe <= !cfg.rel;
            end
            if (fall_ev) sck <= 1'b0;
            if (state == ST_END && cfg.rd && cfg.cnt != '0) data_q <= shreg;
        end
    end
endmodule

// File: rtl/uw_engine_chk.sv
module uw_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ctrl_q,
    input logic [7:0] data_q,
    input logic       sck,
    input logic       sd_oe,
    input logic       irq
);
    // R2
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[7] |-> !sck);

    // R2
    sck_rise_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> ctrl_q[7]);

    // R1
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[7] |=> $stable(ctrl_q[6:0]));

    // R11
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[7] |=> ($stable(data_q) || !ctrl_q[7]));

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[3:0] <= 4'd8);

    // R7
    idle_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[7] |-> (sd_oe == !ctrl_q[5]));

    // R8
    irq_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_q[7]) |-> irq);

    // R8
    irq_only_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $fell(ctrl_q[7]));
endmodule

bind uw_shift_engine uw_engine_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctrl_q (ctrl_q),
    .data_q (data_q),
    .sck    (sck),
    .sd_oe  (sd_oe),
    .irq    (irq)
);

// File: tb/uw_shift_engine_test.sv
`timescale 1ns/1ps
module uw_shift_engine_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_wr_en = 1'b0;
    logic [7:0] data_wr_val = '0;
    logic       ctrl_wr_en = 1'b0;
    logic [7:0] ctrl_wr_val = '0;
    logic [7:0] data_q;
    logic [7:0] ctrl_q;
    logic       sck;
    logic       sd_out;
    logic       sd_oe;
    logic       sd_in = 1'b0;
    logic       irq;

    int total = 0;
    int bad = 0;
    int edges = 0;
    int irq_cnt = 0;
    logic [7:0] cap = '0;
    logic       dev_on = 1'b0;
    logic [7:0] dev_pat = '0;
    int         dev_idx = 0;

    uw_shift_engine uut (
        .clk(clk), .rst_n(rst_n), .data_wr_en(data_wr_en), .data_wr_val(data_wr_val),
        .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_val(ctrl_wr_val), .data_q(data_q),
        .ctrl_q(ctrl_q), .sck(sck), .sd_out(sd_out), .sd_oe(sd_oe),
        .sd_in(sd_in), .irq(irq)
    );

    always #2 clk = ~clk;

    always @(posedge sck) begin
        edges = edges + 1;
        cap = {cap[6:0], sd_out};
    end

    always @(negedge sck) begin
        if (dev_on && dev_idx > 0) begin
            dev_idx = dev_idx - 1;
            sd_in = dev_pat[dev_idx];
        end
    end

    always @(posedge clk) if (irq) irq_cnt = irq_cnt + 1;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic data_wr(input logic [7:0] v);
        @(negedge clk); data_wr_en = 1'b1; data_wr_val = v;
        @(negedge clk); data_wr_en = 1'b0;
    endtask

    task automatic ctrl_wr(input logic [7:0] v);
        @(negedge clk); ctrl_wr_en = 1'b1; ctrl_wr_val = v; edges = 0;
        @(negedge clk); ctrl_wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (ctrl_q[7] && n < 20000) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R10 sck", sck, 0);
        check("R10 busy", ctrl_q[7], 0);
        check("R10 oe", sd_oe, 1);
        check("R10 sd_out", sd_out, 0);
        check("R10 irq", irq, 0);
        check("R10 data", data_q, 0);
        check("R10 ctrl", ctrl_q, 0);
    endtask

    task automatic t_write8();
        int i0 = irq_cnt;
        realtime t0;
        data_wr(8'hA5);
        check("R11 load", data_q, 8'hA5);
        ctrl_wr(8'h08);
        check("R1 busy set", ctrl_q[7], 1);
        @(posedge sck); t0 = $realtime;
        @(negedge sck);
        check("R2 half period", int'(($realtime - t0) / 4.0), 250);
        wait_idle();
        check("R3 edges", edges, 8);
        check("R3 data out", cap, 8'hA5);
        check("R8 one irq", irq_cnt - i0, 1);
        check("R7 driven after", sd_oe, 1);
        check("R2 idle low", sck, 0);
    endtask

    task automatic t_write3_rel();
        data_wr(8'hB7);
        ctrl_wr(8'h23);
        wait (edges == 3);
        @(negedge clk);
        check("R7 sck still high", sck, 1);
        check("R7 released", sd_oe, 0);
        wait_idle();
        check("R3 short edges", edges, 3);
        check("R3 short bits", cap[2:0], 3'b101);
        ctrl_wr(8'h00);
        wait_idle();
        check("R5 redrive", sd_oe, 1);
    endtask

    task automatic t_read(input logic [7:0] cmd, input logic [7:0] pat, input int n,
                          input logic [7:0] exp);
        data_wr(8'hFF);
        dev_pat = pat; dev_idx = n - 1; sd_in = pat[n-1]; dev_on = 1'b1;
        ctrl_wr(cmd);
        check("R4 oe off in read", sd_oe, 0);
        wait_idle();
        dev_on = 1'b0; sd_in = 1'b0;
        check("R4 read edges", edges, n);
        check("R4 read data", data_q, exp);
    endtask

    task automatic t_cnt0();
        int i0 = irq_cnt;
        ctrl_wr(8'h20);
        wait_idle();
        check("R5 no clocks rel", edges, 0);
        check("R5 floated", sd_oe, 0);
        ctrl_wr(8'h00);
        wait_idle();
        check("R5 no clocks", edges, 0);
        check("R5 driven", sd_oe, 1);
        check("R5 driven low", sd_out, 0);
        check("R8 irq per cmd", irq_cnt - i0, 2);
    endtask

    task automatic t_clamp();
        data_wr(8'h3C);
        ctrl_wr(8'h0C);
        check("R6 count stored", ctrl_q[3:0], 8);
        wait_idle();
        check("R6 edges", edges, 8);
        check("R6 data", cap, 8'h3C);
    endtask

    task automatic t_busy_ignore();
        data_wr(8'h96);
        ctrl_wr(8'h08);
        wait (edges == 2);
        @(negedge clk); ctrl_wr_en = 1'b1; ctrl_wr_val = 8'h12;
        data_wr_en = 1'b1; data_wr_val = 8'h00;
        @(negedge clk); ctrl_wr_en = 1'b0; data_wr_en = 1'b0;
        check("R1 ctrl kept", ctrl_q[6:0], 7'h08);
        wait_idle();
        check("R1 edges kept", edges, 8);
        check("R1 data out kept", cap, 8'h96);
        check("R11 data ignored", data_q, 8'h96);
    endtask

    task automatic t_wfr();
        int i0;
        sd_in = 1'b0;
        data_wr(8'h5A);
        i0 = irq_cnt;
        ctrl_wr(8'h68);
        wait (edges == 8);
        @(negedge sck);
        repeat (100) @(negedge clk);
        check("R9 busy held", ctrl_q[7], 1);
        check("R9 no irq yet", irq_cnt - i0, 0);
        sd_in = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 busy done", ctrl_q[7], 0);
        check("R9 irq", irq_cnt - i0, 1);
        sd_in = 1'b0;
        ctrl_wr(8'h48);
        wait_idle();
        check("R9 ignored rel0", ctrl_q[7], 0);
        check("R9 irq rel0", irq_cnt - i0, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write8();
        t_write3_rel();
        t_read(8'h18, 8'h3C, 8, 8'h3C);
        t_read(8'h15, 8'h16, 5, 8'h16);
        t_cnt0();
        t_clamp();
        t_busy_ignore();
        t_wfr();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule